// File: doc/BRIEF.md
# Exception Status and Cause Register Unit

This unit keeps the exception state of a small RISC core. It has three registers. A saved-PC register records the address of the faulting instruction. A cause register records the reason for the last exception and which interrupts are waiting. A status register holds an interrupt mask and a three-level stack of privilege and interrupt-enable pairs.

When the core signals an exception, the unit does three things on the next clock edge. It stores the incremented PC minus one instruction width. It latches the 4-bit reason code. It pushes the privilege stack, so the core enters kernel mode with interrupts off. A return strobe pops the stack again.

Five hardware interrupt lines are sampled into the cause register every cycle, whatever the mask or enable state. An interrupt-take output goes high when a sampled line is also unmasked and the current enable bit is set. Software reads the registers through a small select-and-data port. It can also write the mask, the stack bits and one software pending bit.

Top module: `excStatusUnit`

## Requirements
- R1: After reset the status, cause and saved-PC registers read zero, and `irqTake` is 0.
- R2: One clock edge after `excReq` is high, `epcOut` equals the sampled `excPc` minus 4. On the same edge, cause bits 5:2 equal the sampled `excCode`, whatever code value it is (for example 0 interrupt, 8 syscall, 10 reserved instruction, 12 overflow).
- R3: An exception shifts status bits 5:0 left by two: bits 5:4 take 3:2, bits 3:2 take 1:0, and bits 1:0 become 00. Bit 1 is the user bit (0 means kernel) and bit 0 is the enable bit (1 means enabled).
- R4: A return strobe without an exception shifts status bits 5:0 right by two: bits 1:0 take 3:2, bits 3:2 take 5:4, and bits 5:4 keep their value.
- R5: When `excReq` and `rfeStrobe` are high in the same cycle, only the exception takes effect (R2, R3).
- R6: Cause bits 15:11 equal `irqLines[4:0]` as sampled at the previous clock edge, independent of mask and enable. Software writes to these bits have no effect.
- R7: `irqTake` is 1 exactly when some bit of (cause[15:11] AND status[15:11]) is 1 and status bit 0 is 1. The software pending bit (cause bit 10) does not affect it.
- R8: A software write with select 0 loads status bits 15:8 (mask) and 5:0 (stack) from the write data. All other status bits read 0. If an exception or return falls in the same cycle, the stack follows R3/R4 and the mask still takes the written value.
- R9: A software write with select 1 changes only cause bit 10, and an exception in the same cycle still sets the code. Writes with select 2 or 3 change nothing.
- R10: `swRdata` shows status for select 0, cause for select 1, the saved PC for select 2, and zero for select 3. It follows the registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| excReq | input | 1 | Exception taken this cycle |
| excCode | input | 4 | Reason code for the exception |
| excPc | input | 32 | Incremented PC of the faulting instruction |
| irqLines | input | 5 | Hardware interrupt request levels |
| rfeStrobe | input | 1 | Return from exception |
| swWe | input | 1 | Software write enable |
| swSel | input | 2 | Register select: 0 status, 1 cause, 2 saved PC, 3 none |
| swWdata | input | 32 | Software write data |
| swRdata | output | 32 | Selected register value |
| statusOut | output | 32 | Status register |
| causeOut | output | 32 | Cause register |
| epcOut | output | 32 | Saved PC register |
| irqTake | output | 1 | Unmasked enabled interrupt pending |

## Verification
Two pairs of events can fall in the same cycle. An exception can coincide with a return strobe, and an exception or return can coincide with a software write to status or cause. Directed steps raise these pairs together. A pseudo-random phase also lets them collide freely. Every output is judged after each edge against a behavioural model in the bench, which applies the exception-first order and keeps the written mask while the stack follows the exception or return.

// File: rtl/excPkg.sv
package excPkg;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_CAUSE  = 2'd1,
    SEL_EPC    = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic capture;
    logic stackPush;
    logic stackPop;
    logic stackWr;
    logic maskWr;
    logic swPendWr;
  } excStrobes_t;

endpackage

// File: rtl/excCtrl.sv
module excCtrl
  import excPkg::*;
#(
  parameter int HW_LINES = 5,
  parameter int SEL_W    = 2
) (
  input  logic                excReq,
  input  logic                rfeStrobe,
  input  logic                swWe,
  input  logic [SEL_W-1:0]    swSel,
  input  logic [HW_LINES-1:0] hwPend,
  input  logic [HW_LINES-1:0] hwMask,
  input  logic                curIe,
  output excStrobes_t         strb,
  output logic                irqTake
);

  logic selStatus;
  logic selCause;

  assign selStatus = swWe && (swSel == SEL_W'(SEL_STATUS));
  assign selCause  = swWe && (swSel == SEL_W'(SEL_CAUSE));

  // exception beats return, and both beat a software stack write
  always_comb begin
    strb           = '0;
    strb.capture   = excReq;
    strb.stackPush = excReq;
    strb.stackPop  = rfeStrobe && !excReq;
    strb.stackWr   = selStatus && !excReq && !rfeStrobe;
    strb.maskWr    = selStatus;
    strb.swPendWr  = selCause;
  end

  assign irqTake = (|(hwPend & hwMask)) && curIe;

endmodule

// File: rtl/excRegs.sv
module excRegs
  import excPkg::*;
#(
  parameter int XLEN       = 32,
  parameter int HW_LINES   = 5,
  parameter int SW_LINES   = 1,
  parameter int CODE_W     = 4,
  parameter int SEL_W      = 2,
  parameter int PAIRS      = 3,
  parameter int INSN_BYTES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  excStrobes_t         strb,
  input  logic [CODE_W-1:0]   excCode,
  input  logic [XLEN-1:0]     excPc,
  input  logic [HW_LINES-1:0] irqLines,
  input  logic [SEL_W-1:0]    swSel,
  input  logic [XLEN-1:0]     swWdata,
  output logic [XLEN-1:0]     statusOut,
  output logic [XLEN-1:0]     causeOut,
  output logic [XLEN-1:0]     epcOut,
  output logic [XLEN-1:0]     swRdata,
  output logic [HW_LINES-1:0] hwPend,
  output logic [HW_LINES-1:0] hwMask,
  output logic                curIe
);

  localparam int PAIR_W     = 2;
  localparam int STACK_W    = PAIRS * PAIR_W;
  localparam int MASK_LO    = 8;
  localparam int MASK_W     = 8;
  localparam int PEND_TOP   = 15;
  localparam int HW_LO      = PEND_TOP - HW_LINES + 1;
  localparam int SW_LO      = HW_LO - SW_LINES;
  localparam int HW_MASK_OF = HW_LO - MASK_LO;
  localparam int CODE_LO    = 2;

  logic [STACK_W-1:0]  stackQ;
  logic [MASK_W-1:0]   maskQ;
  logic [SW_LINES-1:0] swPendQ;
  logic [CODE_W-1:0]   codeQ;
  logic [XLEN-1:0]     epcQ;

  // status stack: one flop pair per level
  for (genvar p = 0; p < PAIRS; p++) begin : gPair
    logic [PAIR_W-1:0] below;
    logic [PAIR_W-1:0] above;
    if (p == 0) begin : gBottom
      assign below = '0;
    end else begin : gMid
      assign below = stackQ[(p-1)*PAIR_W +: PAIR_W];
    end
    if (p == PAIRS - 1) begin : gTop
      assign above = stackQ[p*PAIR_W +: PAIR_W];
    end else begin : gLow
      assign above = stackQ[(p+1)*PAIR_W +: PAIR_W];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stackQ[p*PAIR_W +: PAIR_W] <= '0;
      end else if (strb.stackPush) begin
        stackQ[p*PAIR_W +: PAIR_W] <= below;
      end else if (strb.stackPop) begin
        stackQ[p*PAIR_W +: PAIR_W] <= above;
      end else if (strb.stackWr) begin
        stackQ[p*PAIR_W +: PAIR_W] <= swWdata[p*PAIR_W +: PAIR_W];
      end
    end
  end

  // hardware pending: one sampling flop per request line
  for (genvar l = 0; l < HW_LINES; l++) begin : gLine
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) hwPend[l] <= 1'b0;
      else       hwPend[l] <= irqLines[l];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ   <= '0;
      swPendQ <= '0;
      codeQ   <= '0;
      epcQ    <= '0;
    end else begin
      if (strb.maskWr)   maskQ   <= swWdata[MASK_LO +: MASK_W];
      if (strb.swPendWr) swPendQ <= swWdata[SW_LO +: SW_LINES];
      if (strb.capture) begin
        codeQ <= excCode;
        epcQ  <= excPc - XLEN'(INSN_BYTES);
      end
    end
  end

  always_comb begin
    statusOut                      = '0;
    statusOut[MASK_LO +: MASK_W]   = maskQ;
    statusOut[0 +: STACK_W]        = stackQ;
    causeOut                       = '0;
    causeOut[HW_LO +: HW_LINES]    = hwPend;
    causeOut[SW_LO +: SW_LINES]    = swPendQ;
    causeOut[CODE_LO +: CODE_W]    = codeQ;
  end

  assign epcOut = epcQ;
  assign hwMask = maskQ[HW_MASK_OF +: HW_LINES];
  assign curIe  = stackQ[0];

  always_comb begin
    case (regSel_e'(swSel))
      SEL_STATUS: swRdata = statusOut;
      SEL_CAUSE:  swRdata = causeOut;
      SEL_EPC:    swRdata = epcOut;
      default:    swRdata = '0;
    endcase
  end

  logic unusedWdata;
  assign unusedWdata = ^{swWdata[XLEN-1:PEND_TOP+1], swWdata[SW_LO-1:STACK_W]};

  AST_HW_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (hwPend == $past(irqLines))) else $error("hw pending"); // R6

  AST_SWPEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.swPendWr |=> $stable(swPendQ)) else $error("sw pending moved"); // R9

endmodule

// File: rtl/excStatusUnit.sv
module excStatusUnit
  import excPkg::*;
#(
  parameter int XLEN       = 32,
  parameter int HW_LINES   = 5,
  parameter int SW_LINES   = 1,
  parameter int CODE_W     = 4,
  parameter int SEL_W      = 2,
  parameter int PAIRS      = 3,
  parameter int INSN_BYTES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                excReq,
  input  logic [CODE_W-1:0]   excCode,
  input  logic [XLEN-1:0]     excPc,
  input  logic [HW_LINES-1:0] irqLines,
  input  logic                rfeStrobe,
  input  logic                swWe,
  input  logic [SEL_W-1:0]    swSel,
  input  logic [XLEN-1:0]     swWdata,
  output logic [XLEN-1:0]     swRdata,
  output logic [XLEN-1:0]     statusOut,
  output logic [XLEN-1:0]     causeOut,
  output logic [XLEN-1:0]     epcOut,
  output logic                irqTake
);

  localparam int STACK_W = 2 * PAIRS;
  localparam int CODE_LO = 2;

  excStrobes_t         strb;
  logic [HW_LINES-1:0] hwPend;
  logic [HW_LINES-1:0] hwMask;
  logic                curIe;

  excCtrl #(.HW_LINES(HW_LINES), .SEL_W(SEL_W)) uCtrl (
    .excReq(excReq), .rfeStrobe(rfeStrobe), .swWe(swWe), .swSel(swSel),
    .hwPend(hwPend), .hwMask(hwMask), .curIe(curIe),
    .strb(strb), .irqTake(irqTake)
  );

  excRegs #(
    .XLEN(XLEN), .HW_LINES(HW_LINES), .SW_LINES(SW_LINES), .CODE_W(CODE_W),
    .SEL_W(SEL_W), .PAIRS(PAIRS), .INSN_BYTES(INSN_BYTES)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .excCode(excCode), .excPc(excPc),
    .irqLines(irqLines), .swSel(swSel), .swWdata(swWdata),
    .statusOut(statusOut), .causeOut(causeOut), .epcOut(epcOut),
    .swRdata(swRdata), .hwPend(hwPend), .hwMask(hwMask), .curIe(curIe)
  );

  AST_EXC_EPC: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> (epcOut == $past(excPc) - XLEN'(INSN_BYTES))) else $error("epc"); // R2

  AST_EXC_CODE: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> (causeOut[CODE_LO +: CODE_W] == $past(excCode))) else $error("code"); // R2

  AST_EXC_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    excReq |=> (statusOut[STACK_W-1:0] ==
                {$past(statusOut[STACK_W-3:0]), 2'b00})) else $error("push"); // R3

  AST_RFE_POP: assert property (@(posedge clk) disable iff (!rstN)
    (rfeStrobe && !excReq) |=> (statusOut[STACK_W-1:0] ==
                {$past(statusOut[STACK_W-1:STACK_W-2]), $past(statusOut[STACK_W-1:2])}))
    else $error("pop"); // R4

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rstN)
    irqTake |-> statusOut[0]) else $error("irq without enable"); // R7

  AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !excReq |=> $stable(epcOut)) else $error("epc moved"); // R9

endmodule

// File: tb/tb_excStatusUnit.sv
`timescale 1ns/1ps
module tb_excStatusUnit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excReq = 1'b0;
  logic [3:0]  excCode = '0;
  logic [31:0] excPc = '0;
  logic [4:0]  irqLines = '0;
  logic        rfeStrobe = 1'b0;
  logic        swWe = 1'b0;
  logic [1:0]  swSel = '0;
  logic [31:0] swWdata = '0;
  logic [31:0] swRdata, statusOut, causeOut, epcOut;
  logic        irqTake;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [31:0] mStatus, mCause, mEpc;

  always #5 clk = ~clk;

  excStatusUnit dut (
    .clk(clk), .rstN(rstN), .excReq(excReq), .excCode(excCode), .excPc(excPc),
    .irqLines(irqLines), .rfeStrobe(rfeStrobe), .swWe(swWe), .swSel(swSel),
    .swWdata(swWdata), .swRdata(swRdata), .statusOut(statusOut),
    .causeOut(causeOut), .epcOut(epcOut), .irqTake(irqTake)
  );

  task automatic modelUpdate();
    logic [31:0] ns, nc, ne;
    ns = mStatus; nc = mCause; ne = mEpc;
    if (swWe && swSel == 2'd0) begin
      ns[15:8] = swWdata[15:8];
      ns[5:0]  = swWdata[5:0];
    end
    if (excReq)         ns[5:0] = {mStatus[3:0], 2'b00};
    else if (rfeStrobe) ns[5:0] = {mStatus[5:4], mStatus[5:2]};
    nc[15:11] = irqLines;
    if (swWe && swSel == 2'd1) nc[10] = swWdata[10];
    if (excReq) begin
      nc[5:2] = excCode;
      ne = excPc - 32'd4;
    end
    mStatus = ns; mCause = nc; mEpc = ne;
  endtask

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    logic [31:0] rdExp;
    logic        irqExp;
    case (swSel)
      2'd0: rdExp = mStatus;
      2'd1: rdExp = mCause;
      2'd2: rdExp = mEpc;
      default: rdExp = '0;
    endcase
    irqExp = (|(mCause[15:11] & mStatus[15:11])) && mStatus[0];
    cmp(tag, "status", statusOut, mStatus);
    cmp(tag, "cause", causeOut, mCause);
    cmp(tag, "epc", epcOut, mEpc);
    cmp(tag, "irqTake", {31'd0, irqTake}, {31'd0, irqExp});
    cmp({tag, "/R10"}, "swRdata", swRdata, rdExp);
  endtask

  task automatic clearIn();
    excReq = 0; excCode = 0; excPc = 0; rfeStrobe = 0;
    swWe = 0; swSel = 0; swWdata = 0;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
    checkAll(tag);
    clearIn();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    mStatus = '0; mCause = '0; mEpc = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkAll("R1");
    step("R1");

    // status write: mask ff, stack 010101, upper bits ignored
    swWe = 1; swSel = 2'd0; swWdata = 32'hFFFF_FF15; step("R8");
    // overflow exception
    excReq = 1; excCode = 4'd12; excPc = 32'h0000_1000; swSel = 2'd2; step("R2");
    swSel = 2'd1; step("R3");
    swSel = 2'd3; step("R10");
    // return
    rfeStrobe = 1; step("R4");
    // interrupt on line 2, enabled and unmasked
    irqLines = 5'b00100; step("R6");
    step("R7");
    // mask it off: pending stays, no take
    swWe = 1; swSel = 2'd0; swWdata = 32'h0000_0015; step("R7");
    // enable off, mask on
    swWe = 1; swSel = 2'd0; swWdata = 32'h0000_FF14; step("R6");
    irqLines = 5'b10001; step("R6");
    // cause write all ones: only bit 10
    swWe = 1; swSel = 2'd1; swWdata = 32'hFFFF_FFFF; step("R9");
    swSel = 2'd1; step("R7");
    swWe = 1; swSel = 2'd1; swWdata = 32'h0000_0000; step("R9");
    // epc and unused select writes ignored
    swWe = 1; swSel = 2'd2; swWdata = 32'hDEAD_BEEF; step("R9");
    swWe = 1; swSel = 2'd3; swWdata = 32'hDEAD_BEEF; step("R9");
    // exception and return together
    swWe = 1; swSel = 2'd0; swWdata = 32'h0000_FF2D; step("R8");
    excReq = 1; rfeStrobe = 1; excCode = 4'd8; excPc = 32'h0000_0004; step("R5");
    // exception with status write: mask taken, stack pushed
    excReq = 1; excCode = 4'd10; excPc = 32'h8000_0000;
    swWe = 1; swSel = 2'd0; swWdata = 32'h0000_A53F; step("R8");
    // return with cause write, exception with cause write
    rfeStrobe = 1; swWe = 1; swSel = 2'd1; swWdata = 32'h0000_0400; step("R4");
    excReq = 1; excCode = 4'd0; excPc = 32'h0000_0000;
    swWe = 1; swSel = 2'd1; swWdata = 32'h0000_003C; step("R9");
    irqLines = 5'b00000; step("R6");

    lf = 32'hACE1_1357;
    for (int i = 0; i < 120; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      excReq    = lf[0] & lf[1] & lf[2];
      rfeStrobe = lf[3] & lf[4];
      excCode   = lf[8:5];
      excPc     = lf;
      irqLines  = lf[15:11];
      swWe      = lf[16];
      swSel     = lf[18:17];
      swWdata   = {lf[15:0], lf[31:16]};
      step((i % 2 == 0) ? "R7" : "R5");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule